// File: doc/BRIEF.md
# Scaled-Counter Four-Channel PWM Timer

This block is a register-mapped pulse-width timer. A wide free-running counter is viewed through a right shift chosen by a 4-bit scale field. The resulting narrow "scaled count" is compared against four compare registers. Compare channel 0 can serve as the period register. When zero-compare mode is enabled and the scaled count equals channel 0, the wide counter restarts from zero on the next cycle. This fixes the period while keeping the comparators narrow.

Each channel drives a registered PWM output and a pending bit. An output is high while the scaled count is at or above that channel's compare value. Pending bits either track that condition or latch it (sticky mode). Deglitch mode keeps a set output high until the counter passes through zero. The counter can run continuously, or once until its next restart. Software reaches everything through a simple 32-bit write port and a registered read port.

Top module: `pwm_scaled_timer`

## Requirements
- R1: While reset is asserted, and directly after it, every register reads zero: config, counter and compare registers. The counter is stopped, and `pwm_o`, `irq_o` and `bus_rdata_o` are low during reset.
- R2: Register offsets: config 0x00, raw count 0x08, scaled count 0x10, compare n at 0x20+4·n. Compare registers keep only their low CMP_W bits. Unmapped offsets read zero. Config bits 16–19 and 24–27 are stored and read back but change nothing. Config bits 4–7, 11, 14, 15 and 20–23 read zero.
- R3: The scaled count (read at 0x10) equals the raw count shifted right by config bits 3:0, truncated to CMP_W bits.
- R4: The raw counter is CMP_W+15 bits wide. It advances by one per cycle while config bit 12 (always-run) or bit 13 (single-run) is set, and holds otherwise. A write to 0x08 loads it, and the load wins over counting.
- R5: With config bit 9 (zero-compare) set and the counter running, a scaled count equal to compare 0 makes the next raw count zero. The period is therefore (compare0 << scale) + 1 cycles.
- R6: Any restart while running clears config bit 13 by hardware. A restart is either a zero-compare match or a raw count of all ones. With bit 12 clear, the counter then stops.
- R7: The PWM output of channel n goes high in the cycle after the scaled count is greater than or equal to compare n, and goes low in the cycle after that no longer holds (deglitch off).
- R8: Pending bits are config bits 28–31 (channel n at 28+n) and also drive `irq_o`. With config bit 8 (sticky) clear, each bit follows its channel's compare condition one cycle later. With sticky set, a bit is set by the condition and held until software writes config.
- R9: With config bit 10 (deglitch) set, an output that is high stays high until the cycle after the raw count is zero, even if its compare condition drops.
- R10: `bus_rdata_o` shows the register addressed in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bus_addr_i | input | ADDR_W | Byte offset of the register accessed |
| bus_wr_i | input | 1 | Write strobe for the addressed register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data of last cycle's address |
| pwm_o | output | 4 | PWM output per channel |
| irq_o | output | 4 | Pending bit per channel |

## Verification
The bench uses the default compare width of 16, which makes the raw counter 31 bits wide. With that width, a load of 0x7FFFFFFE reaches the all-ones restart within two cycles, so natural wraparound and the single-run clear are checked without a long run. Scale values 0 to 15 cover the full shift range over 31 bits, including truncation of high bits into the 16-bit scaled view. Short compare-0 periods keep whole PWM periods within a few dozen cycles, so duty counts and the counter ceiling can be measured exactly.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  // channel count fixed by the config word layout
  localparam int NCH     = 4;
  localparam int SCALE_W = 4;

  // register byte offsets
  localparam int OFS_CFG = 'h00;
  localparam int OFS_CNT = 'h08;
  localparam int OFS_SCL = 'h10;
  localparam int OFS_CMP = 'h20;
  localparam int CMP_STRIDE = 4;

  // config word bit positions
  localparam int B_STICKY  = 8;
  localparam int B_ZCMP    = 9;
  localparam int B_DGL     = 10;
  localparam int B_ALWAYS  = 12;
  localparam int B_ONESHOT = 13;
  localparam int B_CENTER  = 16;
  localparam int B_GANG    = 24;
  localparam int B_IP      = 28;

  typedef struct packed {
    logic [NCH-1:0]     ip;
    logic [NCH-1:0]     gang;
    logic [NCH-1:0]     center;
    logic               oneshot;
    logic               always_on;
    logic               deglitch;
    logic               zerocmp;
    logic               sticky;
    logic [SCALE_W-1:0] scale;
  } cfg_t;

  function automatic logic [31:0] cfg_pack(input cfg_t c);
    logic [31:0] w;
    w                      = '0;
    w[SCALE_W-1:0]         = c.scale;
    w[B_STICKY]            = c.sticky;
    w[B_ZCMP]              = c.zerocmp;
    w[B_DGL]               = c.deglitch;
    w[B_ALWAYS]            = c.always_on;
    w[B_ONESHOT]           = c.oneshot;
    w[B_CENTER +: NCH]     = c.center;
    w[B_GANG +: NCH]       = c.gang;
    w[B_IP +: NCH]         = c.ip;
    return w;
  endfunction

  function automatic cfg_t cfg_unpack(input logic [31:0] w);
    cfg_t c;
    c.scale     = w[SCALE_W-1:0];
    c.sticky    = w[B_STICKY];
    c.zerocmp   = w[B_ZCMP];
    c.deglitch  = w[B_DGL];
    c.always_on = w[B_ALWAYS];
    c.oneshot   = w[B_ONESHOT];
    c.center    = w[B_CENTER +: NCH];
    c.gang      = w[B_GANG +: NCH];
    c.ip        = w[B_IP +: NCH];
    return c;
  endfunction

endpackage

// File: rtl/pwm_cfg_reg.sv
module pwm_cfg_reg
  import pwm_timer_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_i,
  input  logic           wr_i,
  input  logic [31:0]    wdata_i,
  input  logic           wrap_i,
  input  logic [NCH-1:0] hit_i,
  output cfg_t           cfg_o
);

  cfg_t cfg_q;
  cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_i) begin
      // software write overrides every hardware update this cycle
      cfg_d = cfg_unpack(wdata_i);
    end else begin
      if (wrap_i) begin
        cfg_d.oneshot = 1'b0;
      end
      if (cfg_q.sticky) begin
        cfg_d.ip = cfg_q.ip | hit_i;
      end else begin
        cfg_d.ip = hit_i;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cfg_q <= '0;
    end else begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg_o = cfg_q;

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_timer_pkg::*;
#(
  parameter int CMP_W = 16,
  parameter int CNT_W = CMP_W + 15
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               always_i,
  input  logic               oneshot_i,
  input  logic               zerocmp_i,
  input  logic [SCALE_W-1:0] scale_i,
  input  logic [CMP_W-1:0]   cmp0_i,
  input  logic               load_i,
  input  logic [CNT_W-1:0]   load_val_i,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [CMP_W-1:0]   scaled_o,
  output logic               run_o,
  output logic               wrap_o,
  output logic               zero_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] shifted;
  logic             top_match;
  logic             all_ones;

  always_comb begin
    shifted   = cnt_q >> scale_i;
    scaled_o  = shifted[CMP_W-1:0];
    top_match = zerocmp_i && (scaled_o == cmp0_i);
    all_ones  = &cnt_q;
    run_o     = always_i | oneshot_i;
    wrap_o    = run_o && (top_match || all_ones);
    zero_o    = (cnt_q == '0);
  end

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (run_o) begin
      if (wrap_o) begin
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int CMP_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             wr_i,
  input  logic [CMP_W-1:0] wdata_i,
  input  logic [CMP_W-1:0] scaled_i,
  input  logic             deglitch_i,
  input  logic             restart_i,
  output logic [CMP_W-1:0] cmp_o,
  output logic             hit_o,
  output logic             pwm_o
);

  logic [CMP_W-1:0] cmp_q;
  logic             pwm_q;
  logic             pwm_d;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cmp_q <= '0;
    end else if (wr_i) begin
      cmp_q <= wdata_i;
    end
  end

  always_comb begin
    hit_o = (scaled_i >= cmp_q);
    // deglitch keeps a set output until the raw counter passes zero
    pwm_d = hit_o | (deglitch_i & pwm_q & ~restart_i);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pwm_q <= 1'b0;
    end else begin
      pwm_q <= pwm_d;
    end
  end

  assign cmp_o = cmp_q;
  assign pwm_o = pwm_q;

endmodule

// File: rtl/pwm_scaled_timer.sv
module pwm_scaled_timer
  import pwm_timer_pkg::*;
#(
  parameter int CMP_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic [NCH-1:0]    pwm_o,
  output logic [NCH-1:0]    irq_o
);

  localparam int CNT_W = CMP_W + 15;

  cfg_t             cfg_q;
  logic             cfg_wr;
  logic             cnt_load;
  logic [CNT_W-1:0] cnt_q;
  logic [CMP_W-1:0] scaled;
  logic             run;
  logic             wrap;
  logic             cnt_zero;
  logic [NCH-1:0]   hit;
  logic [NCH-1:0]   cmp_wr;
  logic [CMP_W-1:0] cmp_all [NCH];
  logic [31:0]      rd_d;
  logic [31:0]      rd_q;

  assign cfg_wr   = bus_wr_i && (bus_addr_i == ADDR_W'(OFS_CFG));
  assign cnt_load = bus_wr_i && (bus_addr_i == ADDR_W'(OFS_CNT));

  pwm_cfg_reg u_cfg (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .wr_i    (cfg_wr),
    .wdata_i (bus_wdata_i),
    .wrap_i  (wrap),
    .hit_i   (hit),
    .cfg_o   (cfg_q)
  );

  pwm_counter #(
    .CMP_W (CMP_W),
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .always_i   (cfg_q.always_on),
    .oneshot_i  (cfg_q.oneshot),
    .zerocmp_i  (cfg_q.zerocmp),
    .scale_i    (cfg_q.scale),
    .cmp0_i     (cmp_all[0]),
    .load_i     (cnt_load),
    .load_val_i (bus_wdata_i[CNT_W-1:0]),
    .cnt_o      (cnt_q),
    .scaled_o   (scaled),
    .run_o      (run),
    .wrap_o     (wrap),
    .zero_o     (cnt_zero)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign cmp_wr[g] = bus_wr_i &&
                       (bus_addr_i == ADDR_W'(OFS_CMP + CMP_STRIDE * g));

    pwm_channel #(
      .CMP_W (CMP_W)
    ) u_ch (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .wr_i       (cmp_wr[g]),
      .wdata_i    (bus_wdata_i[CMP_W-1:0]),
      .scaled_i   (scaled),
      .deglitch_i (cfg_q.deglitch),
      .restart_i  (cnt_zero),
      .cmp_o      (cmp_all[g]),
      .hit_o      (hit[g]),
      .pwm_o      (pwm_o[g])
    );
  end

  always_comb begin
    rd_d = '0;
    if (bus_addr_i == ADDR_W'(OFS_CFG)) begin
      rd_d = cfg_pack(cfg_q);
    end else if (bus_addr_i == ADDR_W'(OFS_CNT)) begin
      rd_d = 32'(cnt_q);
    end else if (bus_addr_i == ADDR_W'(OFS_SCL)) begin
      rd_d = 32'(scaled);
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (bus_addr_i == ADDR_W'(OFS_CMP + CMP_STRIDE * i)) begin
          rd_d = 32'(cmp_all[i]);
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rd_q <= '0;
    end else begin
      rd_q <= rd_d;
    end
  end

  assign bus_rdata_o = rd_q;
  assign irq_o       = cfg_q.ip;

endmodule

// File: rtl/pwm_scaled_timer_chk.sv
module pwm_scaled_timer_chk #(
  parameter int CMP_W = 16,
  parameter int CNT_W = CMP_W + 15
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CMP_W-1:0] scaled,
  input logic [CMP_W-1:0] cmp0,
  input logic             run,
  input logic             wrap,
  input logic             cnt_load,
  input logic             cfg_wr,
  input logic             zerocmp,
  input logic             sticky,
  input logic             deglitch,
  input logic             oneshot,
  input logic [3:0]       ip,
  input logic [3:0]       pwm
);

  // R4
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (run && !cnt_load && !wrap) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  // R4
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!run && !cnt_load) |=> $stable(cnt_q));

  // R5
  zero_cmp_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (run && !cnt_load && zerocmp && (scaled == cmp0)) |=> (cnt_q == '0));

  // R6
  oneshot_clr_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (wrap && !cfg_wr) |=> !oneshot);

  for (genvar g = 0; g < 4; g++) begin : g_chk
    // R8
    sticky_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (sticky && !cfg_wr && ip[g]) |=> ip[g]);

    // R9
    dgl_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (deglitch && pwm[g] && (cnt_q != '0)) |=> pwm[g]);
  end

endmodule

bind pwm_scaled_timer pwm_scaled_timer_chk #(
  .CMP_W (CMP_W)
) i_chk (
  .clk_i    (clk_i),
  .rst_i    (rst_i),
  .cnt_q    (cnt_q),
  .scaled   (scaled),
  .cmp0     (cmp_all[0]),
  .run      (run),
  .wrap     (wrap),
  .cnt_load (cnt_load),
  .cfg_wr   (cfg_wr),
  .zerocmp  (cfg_q.zerocmp),
  .sticky   (cfg_q.sticky),
  .deglitch (cfg_q.deglitch),
  .oneshot  (cfg_q.oneshot),
  .ip       (cfg_q.ip),
  .pwm      (pwm_o)
);

// File: tb/test_pwm_scaled_timer.sv
`timescale 1ns/1ps
module test_pwm_scaled_timer;

  localparam logic [7:0] A_CFG = 8'h00;
  localparam logic [7:0] A_CNT = 8'h08;
  localparam logic [7:0] A_SCL = 8'h10;
  localparam logic [7:0] A_C0  = 8'h20;
  localparam logic [7:0] A_C1  = 8'h24;
  localparam logic [7:0] A_C2  = 8'h28;
  localparam logic [7:0] A_C3  = 8'h2C;

  // {scale, raw load value, expected scaled count}
  localparam int NV = 8;
  localparam logic [50:0] VEC [NV] = '{
    {4'd0,  31'h00001234, 16'h1234},
    {4'd4,  31'h00012345, 16'h1234},
    {4'd8,  31'h00ABCDEF, 16'hABCD},
    {4'd15, 31'h7FFFFFFF, 16'hFFFF},
    {4'd1,  31'h0001FFFF, 16'hFFFF},
    {4'd0,  31'h7FFF1234, 16'h1234},
    {4'd12, 31'h12345678, 16'h2345},
    {4'd2,  31'h00000003, 16'h0000}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm;
  logic [3:0]  irq;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  pwm_scaled_timer i_pwm_scaled_timer (
    .clk_i       (clk),
    .rst_i       (rst),
    .bus_addr_i  (bus_addr),
    .bus_wr_i    (bus_wr),
    .bus_wdata_i (bus_wdata),
    .bus_rdata_o (bus_rdata),
    .pwm_o       (pwm),
    .irq_o       (irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2, mx;
    int hi;

    // R1: state during and after reset
    idle(3);
    chk("R1 rdata in reset", bus_rdata, 32'h0);
    chk("R1 pwm in reset", {28'h0, pwm}, 32'h0);
    chk("R1 irq in reset", {28'h0, irq}, 32'h0);
    rst = 1'b0;
    rd(A_CFG, d); chk("R1 config after reset", d, 32'h0);
    rd(A_C2, d);  chk("R1 compare after reset", d, 32'h0);
    rd(A_CNT, d); chk("R1 count after reset", d, 32'h0);
    idle(5);
    rd(A_CNT, d); chk("R1 counter stopped", d, 32'h0);

    // R3 / R4: vector walk of load and scaled view, counter stopped
    for (int k = 0; k < NV; k++) begin
      wr(A_CFG, {28'h0, VEC[k][50:47]});
      wr(A_CNT, {1'b0, VEC[k][46:16]});
      rd(A_SCL, d);
      chk($sformatf("R3 scaled vector %0d", k), d, {16'h0, VEC[k][15:0]});
      rd(A_CNT, d);
      chk($sformatf("R4 loaded count vector %0d", k), d, {1'b0, VEC[k][46:16]});
    end

    // R2: register map, truncation, stored-only fields, unmapped offsets
    wr(A_CFG, 32'h0);
    wr(A_C2, 32'h1234ABCD);
    rd(A_C2, d); chk("R2 compare truncated", d, 32'h0000ABCD);
    wr(A_CNT, 32'h33);
    wr(A_CFG, 32'h0F0F08F0);
    rd(A_CFG, d); chk("R2 stored fields", d & 32'h0FFFFFFF, 32'h0F0F0000);
    idle(5);
    rd(A_CNT, d); chk("R2 stored fields have no effect", d, 32'h33);
    rd(8'h04, d); chk("R2 unmapped reads zero", d, 32'h0);

    // R4 / R10: continuous counting, load while running
    wr(A_CFG, 32'h0);
    wr(A_CNT, 32'd100);
    wr(A_CFG, 32'h00001000);
    rd(A_CNT, d);
    idle(9);
    rd(A_CNT, d2);
    chk("R4 ten cycles advance", d2 - d, 32'd10);
    wr(A_CNT, 32'h500);
    @(negedge clk);
    chk("R4 R10 load wins while running", bus_rdata, 32'h500);
    wr(A_CFG, 32'h0);

    // R5 / R7: period 10, duty above 4
    wr(A_CNT, 32'h0);
    wr(A_C0, 32'd9);
    wr(A_C1, 32'd4);
    wr(A_CFG, 32'h00001200);
    bus_addr = A_CNT;
    idle(5);
    hi = 0; mx = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (pwm[1]) hi++;
      if (bus_rdata > mx) mx = bus_rdata;
    end
    chk("R7 high cycles scale 0", 32'(hi), 32'd24);
    chk("R5 count ceiling scale 0", mx, 32'd9);

    // R5 / R7 / R3: scale 2, period 17
    wr(A_CFG, 32'h0);
    wr(A_CNT, 32'h0);
    wr(A_C0, 32'd4);
    wr(A_C1, 32'd2);
    wr(A_CFG, 32'h00001202);
    bus_addr = A_CNT;
    idle(5);
    hi = 0; mx = 0;
    for (int k = 0; k < 34; k++) begin
      @(negedge clk);
      if (pwm[1]) hi++;
      if (bus_rdata > mx) mx = bus_rdata;
    end
    chk("R7 high cycles scale 2", 32'(hi), 32'd18);
    chk("R5 count ceiling scale 2", mx, 32'd16);

    // R6 / R8: single run with zero-compare and sticky pending bits
    wr(A_CFG, 32'h0);
    wr(A_CNT, 32'h0);
    wr(A_C0, 32'd5);
    wr(A_C1, 32'd3);
    wr(A_C2, 32'hFFFF);
    wr(A_C3, 32'd0);
    wr(A_CFG, 32'h00002300);
    idle(20);
    rd(A_CFG, d); chk("R6 R8 single run config", d, 32'hB0000300);
    chk("R8 sticky irq", {28'h0, irq}, 32'hB);
    rd(A_CNT, d); chk("R6 stopped at zero", d, 32'h0);

    // R8: non-sticky follows compare condition at count 0
    wr(A_CFG, 32'h00000200);
    idle(3);
    chk("R8 non-sticky irq", {28'h0, irq}, 32'h8);

    // R6: natural wrap of the all-ones count
    wr(A_CFG, 32'h0);
    wr(A_CNT, 32'h7FFFFFFE);
    wr(A_CFG, 32'h00002000);
    idle(10);
    rd(A_CFG, d); chk("R6 single-run bit cleared on wrap", d & 32'h00003000, 32'h0);
    rd(A_CNT, d); chk("R6 wrapped and stopped", d, 32'h0);

    // R7 / R9: deglitch hold and release
    wr(A_CFG, 32'h0);
    wr(A_CNT, 32'd7);
    wr(A_C1, 32'd5);
    idle(3);
    chk("R7 output high at or above compare", {31'h0, pwm[1]}, 32'h1);
    wr(A_CFG, 32'h00000400);
    wr(A_C1, 32'd10);
    idle(3);
    chk("R9 deglitch holds output", {31'h0, pwm[1]}, 32'h1);
    wr(A_CNT, 32'd0);
    idle(3);
    chk("R9 released at count zero", {31'h0, pwm[1]}, 32'h0);
    wr(A_CNT, 32'd7);
    wr(A_C1, 32'd5);
    idle(3);
    wr(A_CFG, 32'h0);
    wr(A_C1, 32'd10);
    idle(3);
    chk("R7 drops without deglitch", {31'h0, pwm[1]}, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule